// File: doc/BRIEF.md
# SD Host Interrupt Status and Enable Registers

This block holds the interrupt register set of an SD card host controller. Single-cycle event pulses arrive from the command engine, the data engine, the card-detect logic and the bus supervisor. Each pulse is latched into a 32-bit status register, but only where the matching bit of a status-enable register is set. A second signal-enable register chooses which latched bits may drive the one level-sensitive interrupt line. Software acknowledges events by writing ones into the status register.

Bits 0 to 14 carry normal events, such as command done, transfer end, buffer ready, card inserted or removed, and card interrupt. Bits 16 to 31 carry error events, such as command or data timeout, CRC, end-bit and index faults, bus power, and stop-command errors. Bit 15 is not stored. It reads as the OR of all latched error bits. Two summary outputs report whether any command-related bit or any data-related bit is pending. A separate 16-bit register collects the detail flags for a failing automatic stop command and is also acknowledged by writing ones.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: After reset, the status register (0x30), status-enable register (0x34), signal-enable register (0x38) and stop-error register (0x3C) all read zero, and `irq`, `cmd_pending` and `data_pending` are low.
- R2: On the clock edge where `evt_pulse[i]` is high, status bit i is set if status-enable bit i is set. It stays clear if status-enable bit i is clear. No status bit sets without such a pulse.
- R3: A write to 0x30 clears each status bit whose data bit is 1 and whose byte lane strobe `reg_be[i/8]` is high. All other bits keep their value. A status bit is cleared only by such a write.
- R4: If a clearing write and an enabled event hit the same status bit on the same edge, the bit ends up set.
- R5: Status bit 15 reads as the OR of status bits 31..16. A pulse on `evt_pulse[15]` leaves it unaffected. It returns to zero once all error bits are cleared.
- R6: `irq` is high exactly one clock after a cycle in which the read value of status ANDed with the signal-enable register is non-zero. This includes the bit-15 summary.
- R7: Registers 0x34 and 0x38 are read/write. Only byte lanes with their `reg_be` strobe high are updated.
- R8: `cmd_pending` is the OR of status bits 0, 16, 17, 18 and 19. `data_pending` is the OR of status bits 1, 3, 4, 5, 20, 21 and 22. Other bits, for example bit 6, affect neither output.
- R9: Register 0x3C is 16 bits wide, and its upper read bits are zero. A `stop_err_pulse[j]` sets bit j with no enable. Writing ones under byte lanes 0 and 1 clears bits.
- R10: Reads of any address other than 0x30, 0x34, 0x38 and 0x3C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_be | input | 4 | Byte lane strobes for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 32 | Event pulses, one bit per status bit |
| stop_err_pulse | input | 16 | Stop-command error detail pulses |
| irq | output | 1 | Registered level interrupt |
| cmd_pending | output | 1 | Some command-group status bit is set |
| data_pending | output | 1 | Some data-group status bit is set |

## Verification
Event pulses and register writes take effect at the clock edge that samples them. Their status, enable and stop-error values can therefore be read back at the falling edge that follows. The pending outputs and read data follow the registers combinationally, so they are checked at that same falling edge. `irq` goes through one more register. Each interrupt check samples it twice: at the first falling edge, where it must still hold the old value, and one full clock later, where it must hold the new one. The bench drives every input at a falling edge and samples just after it, so no result depends on process order at the rising edge.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int STOP_W = 16;
  localparam int LANES  = REG_W / 8;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ST_EN  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_SIG_EN = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_STOP   = 8'h3C;

  localparam int          SUM_BIT   = 15;
  localparam logic [REG_W-1:0] SUM_MASK  = 32'h0000_8000;
  localparam logic [REG_W-1:0] ERR_FIELD = 32'hFFFF_0000;
  localparam logic [REG_W-1:0] CMD_GRP   = 32'h000F_0001;
  localparam logic [REG_W-1:0] DATA_GRP  = 32'h0070_003A;

  // Read view of status: stored bits plus the error summary at bit 15.
  function automatic logic [REG_W-1:0] status_view(input logic [REG_W-1:0] raw);
    logic [REG_W-1:0] v;
    v = raw & ~SUM_MASK;
    v[SUM_BIT] = |(raw & ERR_FIELD);
    return v;
  endfunction

  function automatic logic group_hit(input logic [REG_W-1:0] view,
                                     input logic [REG_W-1:0] grp);
    return |(view & grp);
  endfunction
endpackage

// File: rtl/sdh_w1c_bank.sv
module sdh_w1c_bank #(
  parameter int W = 32,
  localparam int NL = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [NL-1:0] be,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  set_vec,
  output logic [W-1:0]  clr_vec,
  output logic [W-1:0]  q
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign clr_vec[l*8 +: 8] = (wr_hit && be[l]) ? wdata[l*8 +: 8] : 8'h00;
  end

  // Set dominates clear on a same-cycle collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/sdh_rw_bank.sv
module sdh_rw_bank #(
  parameter int W = 32,
  localparam int NL = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [NL-1:0] be,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[l*8 +: 8] <= 8'h00;
      else if (wr_hit && be[l])  q[l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [LANES-1:0]  reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [REG_W-1:0]  evt_pulse,
  input  logic [STOP_W-1:0] stop_err_pulse,
  output logic              irq,
  output logic              cmd_pending,
  output logic              data_pending
);
  localparam int STOP_LANES = STOP_W / 8;

  logic [REG_W-1:0]  status_raw, status_rd, st_set, st_clr;
  logic [REG_W-1:0]  sten_q, sigen_q;
  logic [STOP_W-1:0] stop_q, stop_clr;
  logic              sig_hit, irq_q;

  logic hit_status, hit_sten, hit_sigen, hit_stop;
  assign hit_status = reg_wr && (reg_addr == OFF_STATUS);
  assign hit_sten   = reg_wr && (reg_addr == OFF_ST_EN);
  assign hit_sigen  = reg_wr && (reg_addr == OFF_SIG_EN);
  assign hit_stop   = reg_wr && (reg_addr == OFF_STOP);

  // Latch gate: enabled events only, summary position never stored.
  assign st_set = evt_pulse & sten_q & ~SUM_MASK;

  sdh_w1c_bank #(.W(REG_W)) u_status (
    .clk, .rst_n, .wr_hit(hit_status), .be(reg_be), .wdata(reg_wdata),
    .set_vec(st_set), .clr_vec(st_clr), .q(status_raw)
  );

  sdh_rw_bank #(.W(REG_W)) u_sten (
    .clk, .rst_n, .wr_hit(hit_sten), .be(reg_be), .wdata(reg_wdata), .q(sten_q)
  );

  sdh_rw_bank #(.W(REG_W)) u_sigen (
    .clk, .rst_n, .wr_hit(hit_sigen), .be(reg_be), .wdata(reg_wdata), .q(sigen_q)
  );

  sdh_w1c_bank #(.W(STOP_W)) u_stop (
    .clk, .rst_n, .wr_hit(hit_stop), .be(reg_be[STOP_LANES-1:0]),
    .wdata(reg_wdata[STOP_W-1:0]), .set_vec(stop_err_pulse),
    .clr_vec(stop_clr), .q(stop_q)
  );

  assign status_rd    = status_view(status_raw);
  assign cmd_pending  = group_hit(status_rd, CMD_GRP);
  assign data_pending = group_hit(status_rd, DATA_GRP);
  assign sig_hit      = |(status_rd & sigen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sig_hit;
  end
  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_STATUS: reg_rdata = status_rd;
      OFF_ST_EN:  reg_rdata = sten_q;
      OFF_SIG_EN: reg_rdata = sigen_q;
      OFF_STOP:   reg_rdata[STOP_W-1:0] = stop_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk
  import sdh_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [REG_W-1:0]  status_raw,
  input logic [REG_W-1:0]  st_set,
  input logic [REG_W-1:0]  st_clr,
  input logic              sig_hit,
  input logic              irq
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_set != '0) |=> ((status_raw & $past(st_set)) == $past(st_set))); // R4

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> ((status_raw & ~$past(status_raw) & ~$past(st_set)) == '0)); // R2

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (($past(status_raw) & ~status_raw & ~$past(st_clr)) == '0)); // R3

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (irq == $past(sig_hit))); // R6

  AST_STOP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFF_STOP) |-> (reg_rdata[REG_W-1:STOP_W] == '0)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != OFF_STATUS && reg_addr != OFF_ST_EN &&
     reg_addr != OFF_SIG_EN && reg_addr != OFF_STOP) |-> (reg_rdata == '0)); // R10
endmodule

bind sdh_irq_ctrl sdh_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .status_raw(status_raw), .st_set(st_set), .st_clr(st_clr),
  .sig_hit(sig_hit), .irq(irq)
);

// File: tb/sdh_irq_ctrl_bench.sv
module sdh_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse = '0;
  logic [15:0] stop_err_pulse = '0;
  logic        irq, cmd_pending, data_pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdh_irq_ctrl u_sdh_irq_ctrl (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_be, .reg_wdata, .reg_rdata,
    .evt_pulse, .stop_err_pulse, .irq, .cmd_pending, .data_pending
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic pulse(input logic [31:0] e, input logic [15:0] s);
    @(negedge clk);
    evt_pulse = e; stop_err_pulse = s;
    @(negedge clk);
    evt_pulse = '0; stop_err_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h30, v); chk("R1 status", v, 32'h0);
    rd(8'h34, v); chk("R1 status-enable", v, 32'h0);
    rd(8'h38, v); chk("R1 signal-enable", v, 32'h0);
    rd(8'h3C, v); chk("R1 stop-error", v, 32'h0);
    chk("R1 irq/pending", {29'd0, irq, cmd_pending, data_pending}, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    pulse(32'h0001_0003, 16'h0);
    rd(8'h30, v); chk("R2 disabled events not latched", v, 32'h0);
    wr(8'h34, 4'hF, 32'hFFFF_FFFF);
    pulse(32'h0001_0003, 16'h0);
    rd(8'h30, v); chk("R2/R5 enabled events latched with summary", v, 32'h0001_8003);
    chk("R8 both groups pending", {30'd0, cmd_pending, data_pending}, 32'h3);
    @(negedge clk);
    chk("R6 no irq without signal enable", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(8'h30, 4'b0001, 32'h0000_0001);
    rd(8'h30, v); chk("R3 clear bit 0 only", v, 32'h0001_8002);
    wr(8'h30, 4'b0100, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R3/R5 lane 2 clear drops summary", v, 32'h0000_0002);
    wr(8'h30, 4'b0000, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R3 no strobes no effect", v, 32'h0000_0002);
    wr(8'h30, 4'hF, 32'h0000_0000);
    rd(8'h30, v); chk("R3 zeros leave bits", v, 32'h0000_0002);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    pulse(32'h0000_0010, 16'h0);
    @(negedge clk);
    reg_addr = 8'h30; reg_be = 4'hF; reg_wdata = 32'h0000_0010; reg_wr = 1'b1;
    evt_pulse = 32'h0000_0010;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0; evt_pulse = '0;
    rd(8'h30, v); chk("R4 event beats clear", v, 32'h0000_0010);
    wr(8'h30, 4'hF, 32'h0000_0010);
    rd(8'h30, v); chk("R4 clear afterwards", v, 32'h0);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    pulse(32'h0000_8000, 16'h0);
    rd(8'h30, v); chk("R5 pulse on bit 15 ignored", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h38, 4'hF, 32'h0000_0020);
    pulse(32'h0000_0020, 16'h0);
    chk("R6 irq one cycle late (still low)", {31'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 irq rises", {31'd0, irq}, 32'h1);
    chk("R8 buffer-ready is data group", {30'd0, cmd_pending, data_pending}, 32'h1);
    wr(8'h30, 4'hF, 32'h0000_0020);
    chk("R6 irq still high after clear edge", {31'd0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq falls", {31'd0, irq}, 32'h0);
    wr(8'h38, 4'hF, 32'h0000_8000);
    pulse(32'h0010_0000, 16'h0);
    rd(8'h30, v); chk("R5 data timeout with summary", v, 32'h0010_8000);
    @(negedge clk);
    chk("R6 irq via summary enable", {31'd0, irq}, 32'h1);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6 irq drops after error clear", {31'd0, irq}, 32'h0);
    wr(8'h38, 4'hF, 32'h0);
  endtask

  task automatic t_enable_lanes;
    logic [31:0] v;
    wr(8'h34, 4'b1010, 32'hA5A5_A5A5);
    rd(8'h34, v); chk("R7 status-enable lanes 1,3", v, 32'hA5FF_A5FF);
    wr(8'h38, 4'b0101, 32'h1234_5678);
    rd(8'h38, v); chk("R7 signal-enable lanes 0,2", v, 32'h0034_0078);
    wr(8'h34, 4'hF, 32'hFFFF_FFFF);
    wr(8'h38, 4'hF, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    pulse(32'h0, 16'h8001);
    rd(8'h3C, v); chk("R9 stop flags set", v, 32'h0000_8001);
    wr(8'h3C, 4'b0001, 32'hFFFF_0001);
    rd(8'h3C, v); chk("R9 lane 0 clear", v, 32'h0000_8000);
    wr(8'h3C, 4'b0010, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk("R9 lane 1 clear", v, 32'h0);
  endtask

  task automatic t_groups;
    logic [31:0] v;
    pulse(32'h0000_0040, 16'h0);
    chk("R8 card insert in no group", {30'd0, cmd_pending, data_pending}, 32'h0);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    pulse(32'h0002_0000, 16'h0);
    chk("R8 command CRC is command group", {30'd0, cmd_pending, data_pending}, 32'h2);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R10 unmapped reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_w1c();
    t_collide();
    t_summary();
    t_irq();
    t_enable_lanes();
    t_stop();
    t_groups();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule